// File: doc/BRIEF.md
# Address Translation Buffer with Address-Space Tags

This block is a small, fully associative cache of recent virtual-to-physical page translations. A requester presents a virtual address, the identifier of the current address space and a load/store flag. Every entry compares its stored virtual page number and address-space tag against that request at the same time. On a hit, the block answers within the same cycle: it returns the physical address, made from the entry's physical page number and the untranslated 10-bit page offset, along with the entry's status bits. On a miss it raises a miss flag, and an external page-table walker later supplies the translation through the refill port.

Each entry holds a virtual page, a physical page, an address-space tag, a write-permission bit and three state bits: valid, referenced and modified. The block keeps these state bits current as lookups arrive. A store that targets a read-only page is reported as a protection fault. A flush port can remove every entry, or only the entries that belong to one address space. The refill logic never creates two entries for the same page and address space.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the round-robin replacement pointer is at entry 0.
- R2: A lookup hits only if some valid entry has an equal virtual page number (address bits above bit 9) and an equal address-space tag. On a hit the physical address is the entry's physical page number concatenated with lookup address bits 9:0.
- R3: When the lookup is valid, exactly one of hit and miss is high, decided combinationally in the same cycle. Both are low when no lookup is presented, and the physical address output is zero on a miss.
- R4: A hit in a cycle with neither refill nor flush sets the entry's referenced bit at the next clock edge. The hit and referenced outputs show the bit as it was before that access.
- R5: A store that hits an entry with write permission sets the entry's modified bit. A store that hits a read-only entry raises the fault output in the same cycle and leaves the modified bit clear.
- R6: A refill for a new page goes into the lowest-numbered invalid entry when one exists.
- R7: A refill for a new page with all entries valid replaces the entry chosen by the round-robin pointer, and the pointer then advances by one and wraps after the last entry. No other event moves the pointer.
- R8: A refill whose virtual page and address-space tag are already present overwrites that entry in place. At most one entry ever matches a lookup.
- R9: A flush with the all flag set invalidates every entry. Without the all flag it invalidates only the entries whose tag equals the flush tag, and the others stay intact.
- R10: A refilled entry starts with the referenced and modified bits clear. In a cycle that carries a flush, any refill is dropped. A cycle that carries a refill or a flush makes no referenced or modified update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_vaddr | input | VA_W (32) | Virtual address of the lookup |
| lk_asid | input | ASID_W (8) | Current address-space tag |
| lk_store | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_miss | output | 1 | Lookup presented and no entry matched |
| lk_paddr | output | PPN_W+OFS_W (30) | Translated physical address, zero on a miss |
| lk_fault | output | 1 | Store hit a read-only entry |
| lk_writable | output | 1 | Write permission of the matched entry |
| lk_ref | output | 1 | Referenced bit of the matched entry before this access |
| lk_dirty | output | 1 | Modified bit of the matched entry before this access |
| fill_valid | input | 1 | Refill presented this cycle |
| fill_vpn | input | VA_W-OFS_W (22) | Virtual page number to install |
| fill_asid | input | ASID_W (8) | Address-space tag to install |
| fill_ppn | input | PPN_W (20) | Physical page number to install |
| fill_wr | input | 1 | Installed page is writable |
| flush_valid | input | 1 | Flush presented this cycle |
| flush_all | input | 1 | Flush every entry regardless of tag |
| flush_asid | input | ASID_W (8) | Tag selected by a tagged flush |

## Verification
Most internal corruption in this block becomes visible on a later lookup, not at the moment it occurs. A wrong referenced or modified bit appears in the status outputs on the next hit to that page. A wrong victim choice, pointer step or duplicate check appears as an unexpected miss, or as a stale physical page, when the bench later looks up the page that should have been kept. Each lookup is therefore compared on every output against a bench model of all eight entries. The random mix uses few pages and few tags, so evicted, duplicated and flushed pages are looked up again within a few dozen cycles. Directed sequences cover a full buffer, overwrite in place, tagged and full flushes, and refills that collide with a flush.

// File: rtl/xlat_pkg.sv
// Shared types for the translation buffer.
// Assumes: nothing beyond standard packed-struct support.
package xlat_pkg;

    // Per-entry state bits kept beside the tags.
    typedef struct packed {
        logic valid;
        logic wr_ok;
        logic ref_b;
        logic dirty;
    } xlat_flags_t;

    // Next value of a wrapping index in the range [0, n).
    function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/xlat_entry.sv
// One translation entry: tag storage, parallel compare against the lookup
// and refill keys, flush targeting, and reference/dirty maintenance.
// Assumes: ld_en is never raised in a cycle with fl_en (the top gates it),
// and upd_ok is low whenever a refill or flush is presented.
module xlat_entry
    import xlat_pkg::*;
#(
    parameter int VPN_W  = 22,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_on,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    input  logic              upd_ok,
    input  logic              ld_en,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [ASID_W-1:0] ld_asid,
    input  logic [PPN_W-1:0]  ld_ppn,
    input  logic              ld_wr,
    input  logic              fl_en,
    input  logic              fl_all,
    input  logic [ASID_W-1:0] fl_asid,
    output logic              match,
    output logic              dup,
    output xlat_flags_t       flags,
    output logic [PPN_W-1:0]  ppn
);

    xlat_flags_t       flags_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PPN_W-1:0]  ppn_q;
    logic              fl_hit;

    // Lookup match: valid, same page and same address space.
    assign match  = lk_on && flags_q.valid && (vpn_q == lk_vpn) && (asid_q == lk_asid);
    // Refill key already resident in this entry.
    assign dup    = flags_q.valid && (vpn_q == ld_vpn) && (asid_q == ld_asid);
    // This entry is a flush target.
    assign fl_hit = fl_en && (fl_all || (asid_q == fl_asid));

    assign flags = flags_q;
    assign ppn   = ppn_q;

    // Entry state: flush beats refill, refill beats hit update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            vpn_q   <= '0;
            asid_q  <= '0;
            ppn_q   <= '0;
        end else if (fl_hit) begin
            flags_q <= '0;
        end else if (ld_en) begin
            flags_q.valid <= 1'b1;
            flags_q.wr_ok <= ld_wr;
            flags_q.ref_b <= 1'b0;
            flags_q.dirty <= 1'b0;
            vpn_q         <= ld_vpn;
            asid_q        <= ld_asid;
            ppn_q         <= ld_ppn;
        end else if (upd_ok && match) begin
            flags_q.ref_b <= 1'b1;
            if (lk_store && flags_q.wr_ok) begin
                flags_q.dirty <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_victim.sv
// Refill slot selection: an entry already holding the key, else the lowest
// invalid entry, else the round-robin pointer, which only then advances.
// Assumes: dup_vec is one-hot or zero; ENTRIES >= 2.
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    output logic [ENTRIES-1:0] ld_vec
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;
    logic             have_dup;
    logic             use_ptr;

    assign have_dup = |dup_vec;
    assign use_ptr  = fill_go && !have_dup && !free_found;

    // Priority search for the lowest-numbered invalid entry.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // One-hot load strobe for the chosen slot.
    always_comb begin
        if (!fill_go) begin
            ld_vec = '0;
        end else if (have_dup) begin
            ld_vec = dup_vec;
        end else if (free_found) begin
            ld_vec = ENTRIES'(1) << free_idx;
        end else begin
            ld_vec = ENTRIES'(1) << ptr_q;
        end
    end

    // Round-robin pointer, moved only by a replacement of a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (use_ptr) begin
            ptr_q <= IDX_W'(wrap_inc(32'(ptr_q), ENTRIES));
        end
    end

endmodule

// File: rtl/xlat_buffer.sv
// Fully associative translation buffer with address-space tags. Lookups
// are answered combinationally; state changes at the clock edge.
// Assumes: the walker supplies refills only for misses or deliberate
// overwrites; flush in the same cycle as a refill drops the refill.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int OFS_W   = 10,
    parameter int PPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_vaddr,
    input  logic [ASID_W-1:0]      lk_asid,
    input  logic                   lk_store,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PPN_W+OFS_W-1:0] lk_paddr,
    output logic                   lk_fault,
    output logic                   lk_writable,
    output logic                   lk_ref,
    output logic                   lk_dirty,
    input  logic                   fill_valid,
    input  logic [VA_W-OFS_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0]      fill_asid,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   fill_wr,
    input  logic                   flush_valid,
    input  logic                   flush_all,
    input  logic [ASID_W-1:0]      flush_asid
);

    localparam int VPN_W = VA_W - OFS_W;

    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] dup_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] ref_vec;
    logic [ENTRIES-1:0] ld_vec;
    xlat_flags_t        flags_arr [ENTRIES];
    logic [PPN_W-1:0]   ppn_arr   [ENTRIES];
    logic [VPN_W-1:0]   lk_vpn;
    logic               fill_go;
    logic               upd_ok;
    xlat_flags_t        sel_flags;
    logic [PPN_W-1:0]   sel_ppn;

    assign lk_vpn  = lk_vaddr[VA_W-1:OFS_W];
    assign fill_go = fill_valid && !flush_valid;
    assign upd_ok  = !fill_valid && !flush_valid;

    // Entry array, one compare per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        xlat_entry #(
            .VPN_W  (VPN_W),
            .PPN_W  (PPN_W),
            .ASID_W (ASID_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_on    (lk_valid),
            .lk_vpn   (lk_vpn),
            .lk_asid  (lk_asid),
            .lk_store (lk_store),
            .upd_ok   (upd_ok),
            .ld_en    (ld_vec[g]),
            .ld_vpn   (fill_vpn),
            .ld_asid  (fill_asid),
            .ld_ppn   (fill_ppn),
            .ld_wr    (fill_wr),
            .fl_en    (flush_valid),
            .fl_all   (flush_all),
            .fl_asid  (flush_asid),
            .match    (match_vec[g]),
            .dup      (dup_vec[g]),
            .flags    (flags_arr[g]),
            .ppn      (ppn_arr[g])
        );
        assign valid_vec[g] = flags_arr[g].valid;
        assign ref_vec[g]   = flags_arr[g].ref_b;
    end

    xlat_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_go   (fill_go),
        .valid_vec (valid_vec),
        .dup_vec   (dup_vec),
        .ld_vec    (ld_vec)
    );

    // Select the matching entry's page and flags (at most one matches).
    always_comb begin
        sel_ppn   = '0;
        sel_flags = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                sel_ppn   = ppn_arr[i];
                sel_flags = flags_arr[i];
            end
        end
    end

    assign lk_hit      = |match_vec;
    assign lk_miss     = lk_valid && !lk_hit;
    assign lk_paddr    = lk_hit ? {sel_ppn, lk_vaddr[OFS_W-1:0]} : '0;
    assign lk_fault    = lk_hit && lk_store && !sel_flags.wr_ok;
    assign lk_writable = sel_flags.wr_ok;
    assign lk_ref      = sel_flags.ref_b;
    assign lk_dirty    = sel_flags.dirty;

endmodule

// File: rtl/xlat_buffer_chk.sv
// Property checker for the translation buffer, bound into every instance.
// Assumes: internal vectors are reached by name through the bind.
module xlat_buffer_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_store,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_fault,
    input logic               lk_writable,
    input logic               fill_valid,
    input logic               flush_valid,
    input logic               flush_all,
    input logic [ENTRIES-1:0] match_vec,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] ref_vec
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_vec == '0));

    assert_hit_xor_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit ^ lk_miss));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    assert_ref_after_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !fill_valid && !flush_valid)
        |=> ((ref_vec & $past(match_vec)) == $past(match_vec)));

    assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && lk_store && !lk_writable));

    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_all) |=> (valid_vec == '0));

endmodule

bind xlat_buffer xlat_buffer_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_store    (lk_store),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_fault    (lk_fault),
    .lk_writable (lk_writable),
    .fill_valid  (fill_valid),
    .flush_valid (flush_valid),
    .flush_all   (flush_all),
    .match_vec   (match_vec),
    .valid_vec   (valid_vec),
    .ref_vec     (ref_vec)
);

// File: tb/xlat_buffer_bench.sv
// Bench: directed corner cases plus seeded random traffic, compared per
// lookup against an eight-entry model written from the requirements.
module xlat_buffer_bench;

    localparam int PER = 10;
    localparam int N   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic        lk_hit, lk_miss, lk_fault, lk_writable, lk_ref, lk_dirty;
    logic [29:0] lk_paddr;
    logic        fill_valid = 1'b0;
    logic [21:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_wr = 1'b0;
    logic        flush_valid = 1'b0;
    logic        flush_all = 1'b0;
    logic [7:0]  flush_asid = '0;

    int checks = 0;
    int fails  = 0;

    // Model state.
    logic        m_val [N];
    logic [21:0] m_vpn [N];
    logic [7:0]  m_asd [N];
    logic [19:0] m_ppn [N];
    logic        m_wr  [N];
    logic        m_ref [N];
    logic        m_drt [N];
    int          m_ptr;

    always #(PER/2) clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_store(lk_store),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_fault(lk_fault),
        .lk_writable(lk_writable), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_ppn(fill_ppn), .fill_wr(fill_wr),
        .flush_valid(flush_valid), .flush_all(flush_all), .flush_asid(flush_asid)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [21:0] vpn, logic [7:0] asid);
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_vpn[i] == vpn && m_asd[i] == asid) return i;
        return -1;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin
            m_val[i] = 0; m_vpn[i] = 0; m_asd[i] = 0; m_ppn[i] = 0;
            m_wr[i] = 0; m_ref[i] = 0; m_drt[i] = 0;
        end
        m_ptr = 0;
    endfunction

    // One cycle of any combination of lookup, refill and flush.
    task automatic cyc(input logic lv, input logic [21:0] vpn, input logic [7:0] asid,
                       input logic st, input logic [9:0] off,
                       input logic fv, input logic [21:0] fvpn, input logic [7:0] fasid,
                       input logic [19:0] fppn, input logic fwr,
                       input logic xv, input logic xall, input logic [7:0] xasid,
                       input string tag);
        int idx, slot;
        lk_valid = lv; lk_vaddr = {vpn, off}; lk_asid = asid; lk_store = st;
        fill_valid = fv; fill_vpn = fvpn; fill_asid = fasid; fill_ppn = fppn; fill_wr = fwr;
        flush_valid = xv; flush_all = xall; flush_asid = xasid;
        #2;
        idx = lv ? m_find(vpn, asid) : -1;
        chk(tag, "hit", lk_hit, idx >= 0);
        chk(lv ? tag : "R3", "miss", lk_miss, lv && idx < 0);
        if (lv) begin
            chk(tag, "paddr", lk_paddr, (idx >= 0) ? {m_ppn[idx], off} : 30'd0);
            if (idx >= 0) begin
                chk("R5", "fault", lk_fault, st && !m_wr[idx]);
                chk("R4", "ref", lk_ref, m_ref[idx]);
                chk("R5", "dirty", lk_dirty, m_drt[idx]);
                chk("R2", "writable", lk_writable, m_wr[idx]);
            end
        end
        @(posedge clk);
        if (xv) begin
            for (int i = 0; i < N; i++)
                if (xall || m_asd[i] == xasid) begin
                    m_val[i] = 0; m_ref[i] = 0; m_drt[i] = 0; m_wr[i] = 0;
                end
        end else if (fv) begin
            slot = m_find(fvpn, fasid);
            if (slot < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_val[i]) slot = i;
            if (slot < 0) begin
                slot = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_val[slot] = 1; m_vpn[slot] = fvpn; m_asd[slot] = fasid;
            m_ppn[slot] = fppn; m_wr[slot] = fwr; m_ref[slot] = 0; m_drt[slot] = 0;
        end else if (lv && idx >= 0) begin
            m_ref[idx] = 1;
            if (st && m_wr[idx]) m_drt[idx] = 1;
        end
        @(negedge clk);
    endtask

    task automatic look(input logic [21:0] vpn, input logic [7:0] asid, input logic st, input string tag);
        cyc(1, vpn, asid, st, 10'(vpn * 37 + 5), 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input logic [21:0] vpn, input logic [7:0] asid, input logic [19:0] ppn, input logic wr);
        cyc(0, 0, 0, 0, 0, 1, vpn, asid, ppn, wr, 0, 0, 0, "R3");
    endtask

    task automatic flush(input logic all, input logic [7:0] asid);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, all, asid, "R3");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(PER * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1d2c);
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        look(22'd5, 8'd1, 0, "R1");
        look(22'd0, 8'd0, 1, "R1");

        // R6: fill free slots in order; R2 hits and tag mismatch.
        for (int i = 0; i < N; i++) fill(22'(i), 8'd1, 20'(100 + i), i[0]);
        look(22'd3, 8'd1, 0, "R2");
        look(22'd3, 8'd2, 0, "R2");
        look(22'h3fff03, 8'd1, 0, "R2");

        // R5: store to read-only faults, store to writable marks dirty; R4 ref.
        look(22'd2, 8'd1, 1, "R5");
        look(22'd2, 8'd1, 0, "R4");
        look(22'd3, 8'd1, 1, "R5");
        look(22'd3, 8'd1, 0, "R5");

        // R8 and R10: overwrite in place clears ref/dirty, evicts nothing.
        fill(22'd3, 8'd1, 20'd200, 1);
        look(22'd3, 8'd1, 0, "R8");
        look(22'd4, 8'd1, 0, "R8");
        look(22'd0, 8'd1, 0, "R8");

        // R7: full buffer replaces by pointer 0, then 1.
        fill(22'd8, 8'd1, 20'd300, 1);
        look(22'd0, 8'd1, 0, "R7");
        fill(22'd9, 8'd1, 20'd301, 0);
        look(22'd1, 8'd1, 0, "R7");
        look(22'd2, 8'd1, 0, "R7");
        fill(22'd20, 8'd2, 20'd400, 1);

        // R9: tagged flush keeps other address spaces.
        flush(0, 8'd1);
        look(22'd20, 8'd2, 0, "R9");
        look(22'd4, 8'd1, 0, "R9");
        look(22'd8, 8'd1, 0, "R9");

        // R6: refills reuse the freed slots lowest first, then pointer resumes.
        for (int i = 0; i < 7; i++) fill(22'(40 + i), 8'd3, 20'(500 + i), 1);
        fill(22'd60, 8'd3, 20'd600, 1);
        for (int i = 0; i < 7; i++) look(22'(40 + i), 8'd3, 0, "R6");
        look(22'd20, 8'd2, 0, "R6");

        // R10: refill during flush is dropped; lookup during refill leaves ref.
        cyc(0, 0, 0, 0, 0, 1, 22'd70, 8'd4, 20'd700, 1, 1, 0, 8'd9, "R10");
        look(22'd70, 8'd4, 0, "R10");
        cyc(1, 22'd20, 8'd2, 1, 10'd3, 1, 22'd41, 8'd3, 20'd777, 0, 0, 0, 0, "R10");
        look(22'd20, 8'd2, 0, "R10");
        look(22'd41, 8'd3, 1, "R10");

        // R9: flush everything.
        flush(1, 8'd0);
        look(22'd20, 8'd2, 0, "R9");
        look(22'd60, 8'd3, 0, "R9");

        // Random mix over a small page and tag space.
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            logic [21:0] v;
            logic [7:0]  a;
            r = $urandom % 100;
            v = 22'($urandom % 14);
            a = 8'($urandom % 3);
            if (r < 55)
                cyc(1, v, a, ($urandom % 3) == 0, 10'($urandom), 0, 0, 0, 0, 0, 0, 0, 0, "R2");
            else if (r < 90)
                fill(v, a, 20'($urandom), ($urandom % 2) == 1);
            else if (r < 94)
                flush(0, a);
            else if (r < 95)
                flush(1, 0);
            else
                cyc(1, v, a, 1, 10'($urandom), 1, 22'($urandom % 14), a, 20'($urandom), 1,
                    ($urandom % 4) == 0, 0, a, "R10");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule